// File: doc/BRIEF.md
# Per-Stream Delay Scan Sequencer

This block drives a data-delay setting through every legal value while a set of parallel serial streams is being captured, and measures how error-prone each stream is at each setting. A downstream event checker sends one event strobe per checked event together with a per-stream error vector. The block registers these strobes and adds each error to a saturating counter held for the current (setting, stream) pair. After a programmed number of events, the setting advances by one.

When the last setting has been evaluated, every stream is given a class based on its error profile. A setting is good when the stream is enabled and its count is at or below a programmable threshold. A single narrow good region is normal. A single broad good region points to a delay line that runs too fast. Two good regions whose first settings lie a fixed distance apart point to a delay line that runs too slow. Any other profile is reported as bad.

A host reads the status, the classes and every counter through a simple register port. Scans are started through the same port.

Top module: `delay_scan_seq`

## Requirements
- R1: `delay_o` starts each scan at 0 and steps by exactly one up to NUM_STEPS-1 (24). Each step lasts for its configured events plus one evaluation cycle. The value is held after the scan ends, and the diagnostic selector value DIAG_SEL (26) is never driven.
- R2: Writing 1 to bit 0 of address 0 while idle starts a scan. On the next cycle the block is busy, done is cleared, the delay is 0, and all counters and class state are cleared. The same write while busy is ignored.
- R3: The event and error inputs are registered once before use. A registered event seen while running increments the counter of the current setting for every enabled stream whose error bit is set. Registered events that arrive while idle or in the evaluation cycle are dropped.
- R4: The enable mask is latched at scan start. A disabled stream never counts and is always classed bad.
- R5: Counters saturate at 2^CNT_W-1 and never wrap.
- R6: Address 1 holds the events per step (EVT_W bits, reset 1). A value of 0 behaves as 1, so a scan with one event per step takes NUM_STEPS*2+1 cycles from the start edge to done when events arrive continuously.
- R7: Reading address 0 returns bit 0 busy and bit 1 done. The two are never both set, and done rises only when the delay is at the last setting.
- R8: Address 2 is the good threshold (CNT_W bits, reset 0). Address 3 returns, for stream s, a class code in bits [2s+1:2s]. The codes are: 0 normal (one region narrower than WIDE_MIN=4), 2 fast (one region of at least 4 settings), 1 slow (exactly two regions whose starts differ by SLOW_GAP=14), 3 bad (anything else).
- R9: An address with bit 9 set reads a counter, with the setting in bits [8:4] and the stream in bits [3:0]. A setting or stream out of range reads 0, as does any unused control address.
- R10: After reset, the delay is 0, status is 0, events per step is 1, the threshold is 0, every class is 3, and every counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| delay_o | output | DLY_W (5) | Delay setting sent to the delay elements |
| evt_i | input | 1 | One pulse per checked event |
| err_i | input | NUM_STREAMS (12) | Per-stream error flags, valid with evt_i |
| en_mask_i | input | NUM_STREAMS (12) | Stream enable mask, one bit per stream |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (10) | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |

## Verification
Two events can coincide at the end of each step. The final event of a step, carrying its error flags, is counted on the same edge that closes the step. On the next edge, the evaluation drops the strobe that is already waiting in the input register. The bench holds the event strobe high through every scan and flips the error pattern on the setting the bench expects. As a result, one stale error from the previous setting reaches the first count of each new setting. A hand-derived count of exactly one at stream 0, setting 8, together with a per-clock behavioural model, shows whether the boundary event landed in the right cell. A start write injected mid-scan also coincides with counting, and a check confirms the delay does not restart.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_SLOW   = 2'd1,
    CLS_FAST   = 2'd2,
    CLS_BAD    = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EVAL = 2'd2
  } seq_st_e;
endpackage

// File: rtl/dscan_sequencer.sv
module dscan_sequencer
  import dscan_pkg::*;
#(
  parameter int NUM_STEPS = 25,
  parameter int EVT_W     = 16,
  parameter int STEP_W    = $clog2(NUM_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              evt_i,
  input  logic [EVT_W-1:0]  epr_i,
  output logic [STEP_W-1:0] step_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              clear_o,
  output logic              count_o,
  output logic              eval_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_st_e           st_q;
  logic [EVT_W-1:0]  evt_cnt_q;
  logic [EVT_W-1:0]  last_idx;
  logic [STEP_W-1:0] step_q;
  logic              done_q;

  // R6: zero events per step behaves as one
  assign last_idx = (epr_i == '0) ? '0 : epr_i - 1'b1;

  assign clear_o = start_i && (st_q == ST_IDLE);
  assign count_o = evt_i && (st_q == ST_RUN);
  assign eval_o  = (st_q == ST_EVAL);
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign step_o  = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      step_q    <= '0;
      evt_cnt_q <= '0;
      done_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q      <= ST_RUN;
            step_q    <= '0;
            evt_cnt_q <= '0;
            done_q    <= 1'b0;
          end
        end
        ST_RUN: begin
          if (evt_i) begin
            if (evt_cnt_q >= last_idx) begin
              evt_cnt_q <= '0;
              st_q      <= ST_EVAL;
            end else begin
              evt_cnt_q <= evt_cnt_q + 1'b1;
            end
          end
        end
        ST_EVAL: begin
          if (step_q == LAST_STEP) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= ST_RUN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dscan_err_table.sv
module dscan_err_table #(
  parameter int NUM_STREAMS = 12,
  parameter int NUM_STEPS   = 25,
  parameter int CNT_W       = 12,
  parameter int STEP_W      = $clog2(NUM_STEPS),
  parameter int STR_W       = $clog2(NUM_STREAMS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              inc_i,
  input  logic [NUM_STREAMS-1:0]            err_i,
  input  logic [STEP_W-1:0]                 step_i,
  input  logic [STEP_W-1:0]                 rd_step_i,
  input  logic [STR_W-1:0]                  rd_str_i,
  output logic [CNT_W-1:0]                  rd_cnt_o,
  output logic [NUM_STREAMS-1:0][CNT_W-1:0] cur_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_STEPS][NUM_STREAMS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_STEPS; i++)
        for (int j = 0; j < NUM_STREAMS; j++) cnt_q[i][j] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < NUM_STEPS; i++)
        for (int j = 0; j < NUM_STREAMS; j++) cnt_q[i][j] <= '0;
    end else if (inc_i) begin
      // R5: hold at all-ones
      for (int j = 0; j < NUM_STREAMS; j++)
        if (err_i[j] && cnt_q[step_i][j] != CNT_MAX)
          cnt_q[step_i][j] <= cnt_q[step_i][j] + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_cur
    assign cur_cnt_o[g] = cnt_q[step_i][g];
  end

  // R9: out-of-range cells read zero
  always_comb begin
    rd_cnt_o = '0;
    if (int'(rd_step_i) < NUM_STEPS && int'(rd_str_i) < NUM_STREAMS)
      rd_cnt_o = cnt_q[rd_step_i][rd_str_i];
  end
endmodule

// File: rtl/dscan_classifier.sv
module dscan_classifier
  import dscan_pkg::*;
#(
  parameter int NUM_STREAMS = 12,
  parameter int CNT_W       = 12,
  parameter int STEP_W      = 5,
  parameter int SLOW_GAP    = 14,
  parameter int WIDE_MIN    = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clear_i,
  input  logic                              eval_i,
  input  logic [STEP_W-1:0]                 step_i,
  input  logic [NUM_STREAMS-1:0]            mask_i,
  input  logic [CNT_W-1:0]                  thresh_i,
  input  logic [NUM_STREAMS-1:0][CNT_W-1:0] cnt_i,
  output logic [NUM_STREAMS-1:0][1:0]       cls_o
);
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_str
    logic              good;
    logic              prev_q;
    logic [1:0]        nreg_q;
    logic [STEP_W-1:0] start0_q, start1_q, width0_q;
    cls_e              cls;

    // R4, R8: disabled streams are never good
    assign good = mask_i[g] && (cnt_i[g] <= thresh_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q   <= 1'b0;
        nreg_q   <= '0;
        start0_q <= '0;
        start1_q <= '0;
        width0_q <= '0;
      end else if (clear_i) begin
        prev_q   <= 1'b0;
        nreg_q   <= '0;
        start0_q <= '0;
        start1_q <= '0;
        width0_q <= '0;
      end else if (eval_i) begin
        prev_q <= good;
        if (good && !prev_q) begin
          if (nreg_q != 2'd3) nreg_q <= nreg_q + 1'b1;
          if (nreg_q == 2'd0) start0_q <= step_i;
          if (nreg_q == 2'd1) start1_q <= step_i;
        end
        // width of the first region only
        if (good && ((!prev_q && nreg_q == 2'd0) || (prev_q && nreg_q == 2'd1)))
          width0_q <= width0_q + 1'b1;
      end
    end

    always_comb begin
      cls = CLS_BAD;
      if (nreg_q == 2'd1)
        cls = (int'(width0_q) >= WIDE_MIN) ? CLS_FAST : CLS_NORMAL;
      else if (nreg_q == 2'd2 && (int'(start1_q) - int'(start0_q)) == SLOW_GAP)
        cls = CLS_SLOW;
    end

    assign cls_o[g] = cls;
  end
endmodule

// File: rtl/delay_scan_seq.sv
module delay_scan_seq
  import dscan_pkg::*;
#(
  parameter int NUM_STREAMS = 12,
  parameter int NUM_STEPS   = 25,
  parameter int CNT_W       = 12,
  parameter int EVT_W       = 16,
  parameter int SLOW_GAP    = 14,
  parameter int WIDE_MIN    = 4,
  parameter int DIAG_SEL    = 26,
  parameter int DLY_W       = $clog2(DIAG_SEL + 1),
  parameter int ADDR_W      = $clog2(NUM_STREAMS) + $clog2(NUM_STEPS) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  output logic [DLY_W-1:0]       delay_o,
  input  logic                   evt_i,
  input  logic [NUM_STREAMS-1:0] err_i,
  input  logic [NUM_STREAMS-1:0] en_mask_i,
  input  logic                   reg_wr_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o
);
  localparam int STR_AW  = $clog2(NUM_STREAMS);
  localparam int STEP_AW = $clog2(NUM_STEPS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EPR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLS  = ADDR_W'(3);

  logic                              evt_q;
  logic [NUM_STREAMS-1:0]            err_q;
  logic [NUM_STREAMS-1:0]            mask_q;
  logic [EVT_W-1:0]                  epr_q;
  logic [CNT_W-1:0]                  thr_q;
  logic                              tbl_sel, start, busy, done, clear, count, eval;
  logic [STEP_AW-1:0]                step;
  logic [CNT_W-1:0]                  rd_cnt;
  logic [NUM_STREAMS-1:0][CNT_W-1:0] cur_cnt;
  logic [NUM_STREAMS-1:0][1:0]       cls;

  assign tbl_sel = reg_addr_i[ADDR_W-1];
  assign start   = reg_wr_i && !tbl_sel && (reg_addr_i == A_CTRL) && reg_wdata_i[0];

  // R3: strobes registered before use
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      err_q <= '0;
    end else begin
      evt_q <= evt_i;
      err_q <= err_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epr_q  <= EVT_W'(1);
      thr_q  <= '0;
      mask_q <= '0;
    end else begin
      if (reg_wr_i && !tbl_sel && reg_addr_i == A_EPR) epr_q <= reg_wdata_i[EVT_W-1:0];
      if (reg_wr_i && !tbl_sel && reg_addr_i == A_THR) thr_q <= reg_wdata_i[CNT_W-1:0];
      if (clear) mask_q <= en_mask_i; // R4
    end
  end

  dscan_sequencer #(
    .NUM_STEPS(NUM_STEPS), .EVT_W(EVT_W), .STEP_W(STEP_AW)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .evt_i(evt_q), .epr_i(epr_q),
    .step_o(step), .busy_o(busy), .done_o(done),
    .clear_o(clear), .count_o(count), .eval_o(eval)
  );

  dscan_err_table #(
    .NUM_STREAMS(NUM_STREAMS), .NUM_STEPS(NUM_STEPS), .CNT_W(CNT_W),
    .STEP_W(STEP_AW), .STR_W(STR_AW)
  ) u_tbl (
    .clk_i, .rst_ni,
    .clear_i(clear), .inc_i(count), .err_i(err_q & mask_q),
    .step_i(step),
    .rd_step_i(reg_addr_i[STR_AW +: STEP_AW]),
    .rd_str_i(reg_addr_i[STR_AW-1:0]),
    .rd_cnt_o(rd_cnt), .cur_cnt_o(cur_cnt)
  );

  dscan_classifier #(
    .NUM_STREAMS(NUM_STREAMS), .CNT_W(CNT_W), .STEP_W(STEP_AW),
    .SLOW_GAP(SLOW_GAP), .WIDE_MIN(WIDE_MIN)
  ) u_cls (
    .clk_i, .rst_ni,
    .clear_i(clear), .eval_i(eval), .step_i(step),
    .mask_i(mask_q), .thresh_i(thr_q), .cnt_i(cur_cnt),
    .cls_o(cls)
  );

  assign delay_o = DLY_W'(step);

  always_comb begin
    reg_rdata_o = '0;
    if (tbl_sel) begin
      reg_rdata_o[CNT_W-1:0] = rd_cnt;
    end else begin
      unique case (reg_addr_i)
        A_CTRL:  reg_rdata_o[1:0] = {done, busy};
        A_EPR:   reg_rdata_o[EVT_W-1:0] = epr_q;
        A_THR:   reg_rdata_o[CNT_W-1:0] = thr_q;
        A_CLS:   reg_rdata_o[2*NUM_STREAMS-1:0] = cls;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dscan_chk.sv
module dscan_chk #(
  parameter int NUM_STEPS = 25,
  parameter int DLY_W     = 5,
  parameter int DIAG_SEL  = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DLY_W-1:0] delay_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             start_i
);
  assert_delay_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(delay_i) < NUM_STEPS) && (int'(delay_i) != DIAG_SEL));

  assert_step_by_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (delay_i == $past(delay_i)) || (delay_i == $past(delay_i) + 1'b1));

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (busy_i && !done_i && delay_i == '0));

  assert_busy_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));

  assert_done_at_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (int'(delay_i) == NUM_STEPS - 1));
endmodule

bind delay_scan_seq dscan_chk #(
  .NUM_STEPS(NUM_STEPS), .DLY_W(DLY_W), .DIAG_SEL(DIAG_SEL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .delay_i(delay_o),
  .busy_i(busy), .done_i(done), .start_i(start)
);

// File: tb/sim_delay_scan_seq.sv
module sim_delay_scan_seq;
  localparam int NS  = 12;
  localparam int NST = 25;
  localparam int CW  = 6;
  localparam int SAT = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt;
  logic [11:0] err, mask;
  logic        wr;
  logic [9:0]  addr;
  logic [31:0] wdata, rdata;
  logic [4:0]  delay;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #2 clk = ~clk; // 250 MHz

  delay_scan_seq #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .delay_o(delay), .evt_i(evt), .err_i(err),
    .en_mask_i(mask), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata)
  );

  // behavioural reference
  int        m_state, m_step, m_evt_cnt, m_epr, m_thr, m_thr_scan;
  bit        m_done, m_evt_q, m_start;
  bit [11:0] m_err_q, m_mask;
  int        m_cnt [NST][NS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_step = 0; m_evt_cnt = 0; m_done = 0; m_evt_q = 0;
      m_err_q = 0; m_mask = 0; m_epr = 1; m_thr = 0; m_thr_scan = 0;
      foreach (m_cnt[i, j]) m_cnt[i][j] = 0;
    end else begin
      m_start = wr && addr == 10'd0 && wdata[0];
      case (m_state)
        0: if (m_start) begin
          foreach (m_cnt[i, j]) m_cnt[i][j] = 0;
          m_step = 0; m_evt_cnt = 0; m_done = 0; m_mask = mask;
          m_thr_scan = m_thr; m_state = 1;
        end
        1: if (m_evt_q) begin
          for (int s = 0; s < NS; s++)
            if (m_err_q[s] && m_mask[s] && m_cnt[m_step][s] < SAT) m_cnt[m_step][s]++;
          if (m_evt_cnt >= ((m_epr == 0) ? 1 : m_epr) - 1) begin
            m_evt_cnt = 0; m_state = 2;
          end else m_evt_cnt++;
        end
        default: if (m_step == NST - 1) begin m_state = 0; m_done = 1; end
                 else begin m_step++; m_state = 1; end
      endcase
      m_evt_q = evt; m_err_q = err;
      if (wr && addr == 10'd1) m_epr = int'(wdata[15:0]);
      if (wr && addr == 10'd2) m_thr = int'(wdata[CW-1:0]);
    end
  end

  function automatic int m_class(int s);
    int starts[$], widths[$];
    bit prev = 0;
    if (!m_mask[s]) return 3;
    for (int t = 0; t < NST; t++) begin
      bit g = (m_cnt[t][s] <= m_thr_scan);
      if (g && !prev) begin starts.push_back(t); widths.push_back(1); end
      else if (g) widths[widths.size() - 1]++;
      prev = g;
    end
    if (starts.size() == 1) return (widths[0] >= 4) ? 2 : 0;
    if (starts.size() == 2 && starts[1] - starts[0] == 14) return 1;
    return 3;
  endfunction

  function automatic longint exp_rd(logic [9:0] a);
    longint v = 0;
    if (a[9]) begin
      if (int'(a[8:4]) < NST && int'(a[3:0]) < NS) v = m_cnt[a[8:4]][a[3:0]];
    end else case (a)
      10'd0: v = {m_done, m_state != 0};
      10'd1: v = m_epr;
      10'd2: v = m_thr;
      10'd3: for (int s = 0; s < NS; s++) v |= longint'(m_class(s)) << (2 * s);
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(logic [9:0] a);
    if (a[9]) return "R3 counter";
    case (a)
      10'd0: return "R7 status";
      10'd1: return "R6 events per step";
      10'd2, 10'd3: return "R8 threshold/class";
      default: return "R9 unused address";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(int'(delay) == m_step, "R1 delay", delay, m_step);
      if (m_state == 0 || addr <= 10'd2)
        chk(rdata == exp_rd(addr), tag_of(addr), rdata, exp_rd(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [9:0] tbl(int st, int s);
    return 10'h200 | 10'(st << 4) | 10'(s);
  endfunction

  task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd_chk(input logic [9:0] a, input longint exp, input string tag);
    @(negedge clk); addr = a;
    @(posedge clk); #1;
    chk(rdata == exp, tag, rdata, exp);
    @(negedge clk); addr = 0;
  endtask

  // scan A profiles by stream index mod 5
  function automatic bit good_a(int s, int t);
    case (s % 5)
      0: return t >= 8 && t <= 10;
      1: return (t >= 4 && t <= 5) || (t >= 18 && t <= 19);
      2: return t >= 13 && t <= 18;
      3: return (t >= 3 && t <= 4) || (t >= 13 && t <= 14);
      default: return 0;
    endcase
  endfunction

  task automatic run_scan(input int kind, input bit inject, output int cycles);
    int since = -1;
    @(negedge clk); wr = 1; addr = 0; wdata = 1;
    @(posedge clk); // start edge
    cycles = 0;
    do begin
      @(negedge clk);
      wr = 0; addr = 0; wdata = 0; evt = 1;
      for (int s = 0; s < NS; s++)
        err[s] = (kind == 0) ? !good_a(s, m_step) : (kind == 1);
      if (inject && since < 0 && m_step == 5) begin
        wr = 1; wdata = 1; since = 0;
      end
      @(posedge clk); cycles++; #1;
      if (since >= 0) since++;
      if (since == 3) chk(int'(delay) == 5, "R2 start ignored while busy", delay, 5);
    end while (m_state != 0);
    @(negedge clk); evt = 0; err = 0;
  endtask

  initial begin
    int cyc_n, cw;
    rst_n = 0; evt = 0; err = 0; mask = 12'hFFF; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset values, R9 address range
    chk(delay == 0, "R10 delay at reset", delay, 0);
    rd_chk(10'd0, 0, "R10 status");
    rd_chk(10'd1, 1, "R10 events per step");
    rd_chk(10'd2, 0, "R10 threshold");
    rd_chk(10'd3, 64'hFFFFFF, "R10 class");
    rd_chk(tbl(0, 0), 0, "R10 counter");
    rd_chk(10'h3F0, 0, "R9 setting out of range");
    rd_chk(tbl(0, 12), 0, "R9 stream out of range");
    rd_chk(10'd7, 0, "R9 unused address");

    // scan A: profiles, threshold 1 tolerates the one stale boundary error
    wr_reg(10'd1, 4); wr_reg(10'd2, 1); mask = 12'h7FF;
    run_scan(0, 0, cyc_n);
    rd_chk(10'd0, 2, "R7 done after scan");
    cw = 0;
    for (int s = 0; s < NS; s++) begin
      int c;
      c = (s == 11) ? 3 : (s % 5 == 0) ? 0 : (s % 5 == 1) ? 1 : (s % 5 == 2) ? 2 : 3;
      cw |= c << (2 * s);
    end
    rd_chk(10'd3, cw, "R8 class per profile, R4 masked stream bad");
    rd_chk(tbl(0, 3), 4, "R3 errors counted per event");
    rd_chk(tbl(8, 0), 1, "R3 registered boundary event in new setting");
    rd_chk(tbl(9, 0), 0, "R3 good setting");
    rd_chk(tbl(5, 11), 0, "R4 disabled stream never counts");

    // scan B: saturation, start while busy
    wr_reg(10'd1, 70); wr_reg(10'd2, 0); mask = 12'hFFF;
    run_scan(1, 1, cyc_n);
    rd_chk(tbl(24, 5), SAT, "R5 saturate");
    rd_chk(tbl(3, 0), SAT, "R5 saturate");
    rd_chk(10'd3, 64'hFFFFFF, "R8 no good region is bad");

    // scan C: events per step 0 acts as 1; first event enters the register after the start edge
    wr_reg(10'd1, 0);
    run_scan(2, 0, cyc_n);
    chk(cyc_n == 2 * NST + 1, "R6 zero events per step", cyc_n, 2 * NST + 1);
    rd_chk(10'd3, 64'hAAAAAA, "R8 single wide region is fast");
    wr_reg(10'd1, 1);
    run_scan(2, 0, cyc_n);
    chk(cyc_n == 2 * NST + 1, "R6 one event per step", cyc_n, 2 * NST + 1);
    chk(int'(delay) == NST - 1, "R1 delay held at last setting", delay, NST - 1);

    // R3: events while idle are dropped
    @(negedge clk); evt = 1; err = 12'hFFF;
    repeat (5) @(negedge clk);
    evt = 0; err = 0;
    rd_chk(tbl(24, 0), 0, "R3 idle events ignored");
    rd_chk(tbl(0, 7), 0, "R3 idle events ignored");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule